// File: doc/BRIEF.md
# Modulus Timing Generator

This block produces the timing for a parallel-to-serial video shifter that runs on a fast bit clock. A modulus counter counts the cycles of one parallel word. A mode input sets its length n to 4, 5 or 8. At each word boundary the block pulses a load strobe for the serializer. It also drives a slow clock, which has one period per word.

Several shifters can be made to run in phase. The slow clock of a master device drives the sync input of one or more slaves. In a shared-clock arrangement, every device instead receives one common external slow clock that equals the bit clock divided by n. A rising edge on the sync input re-aligns the counter. The block reports lock once the edges arrive every n cycles and already fall on the word boundary. The sync input is assumed to be synchronous to the bit clock.

Top module: `modulus_timing_gen`

## Requirements
- R1: The mode code sets the word length n: code 0 gives 4, code 1 gives 5, codes 2 and 3 both give 8. With no sync rising edge and no mode change, the counter free-runs and the load strobe repeats every n cycles.
- R2: `loadStb` is high for exactly one cycle in each word, in the cycle where the word count is zero.
- R3: `slowClk` is high for the first floor(n/2) cycles of each word, starting in the load cycle, and low for the rest of the word.
- R4: When a rising edge of `syncIn` is seen at a clock edge (high now, low at the previous edge), the count is zero in the cycle that follows. `loadStb` is therefore high in that cycle.
- R5: When `modeSel` differs from the code in use at a clock edge, the count restarts at zero in the next cycle and `locked` is cleared. This takes priority over a simultaneous sync edge.
- R6: `locked` goes high in the cycle after a sync rising edge that comes exactly n cycles after the previous edge and finds the count at n-1. From the first edge of a steady sync clock, lock is reached within 2n cycles.
- R7: A sync rising edge that fails the R6 test clears `locked` in the next cycle.
- R8: While and just after reset, the count is zero, so `loadStb` is 1 and `slowClk` is 1, and `locked` is 0.
- R9: A slave whose `syncIn` is driven by a master's `slowClk`, in the same mode, settles with its `loadStb` exactly one cycle after the master's, and then reports lock.
- R10: Holding `syncIn` high without a new rising edge has no effect on the count: the word timing free-runs as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Word-length code (0:4, 1:5, 2/3:8) |
| syncIn | input | 1 | External slow clock used for alignment |
| loadStb | output | 1 | One-cycle strobe at each word boundary |
| slowClk | output | 1 | Slow clock, one period per word |
| locked | output | 1 | Sync edges are aligned with the word boundary |

## Verification
Every result is due one clock edge after the input that causes it. A sync edge or a mode change sampled at edge k sets the count, `loadStb`, `slowClk` and `locked` that appear after edge k. The bench therefore drives its inputs at the falling edge, updates its model at the rising edge, and compares all three outputs at the next falling edge. A slave fed by a master lags by one extra register stage, so its strobe is compared with the master's value from the previous sample.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearCnt;   // force the word count to zero next cycle
    logic restart;    // the clear comes from a mode change
    logic syncEdge;   // a sync rising edge was seen
  } strobeT;

endpackage

// File: rtl/mtg_ctrl.sv
module mtg_ctrl
  import mtg_pkg::*;
#(
  parameter int LEN0  = 4,
  parameter int LEN1  = 5,
  parameter int LEN2  = 8,
  parameter int CNT_W = 3,
  parameter int LEN_W = CNT_W + 1,
  parameter int GAP_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] cnt,
  output strobeT           strobes,
  output logic [LEN_W-1:0] curLen,
  output logic             locked
);

  localparam logic [GAP_W-1:0] GAP_SAT = '1;

  logic [1:0]       modeReg;
  logic             syncPrev;
  logic [GAP_W-1:0] gapCnt;
  logic             modeChg;
  logic             edgeDet;
  logic             aligned;
  logic [LEN_W-1:0] lastPos;

  always_comb begin
    case (modeReg)
      2'd0:    curLen = LEN_W'(LEN0);
      2'd1:    curLen = LEN_W'(LEN1);
      default: curLen = LEN_W'(LEN2);
    endcase
  end

  assign modeChg = (modeSel != modeReg);
  assign edgeDet = syncIn & ~syncPrev;
  assign lastPos = curLen - LEN_W'(1);
  assign aligned = (gapCnt == GAP_W'(curLen)) && ({1'b0, cnt} == lastPos);

  always_comb begin
    strobes.restart  = modeChg;
    strobes.syncEdge = edgeDet;
    strobes.clearCnt = modeChg | edgeDet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= 2'd0;
      syncPrev <= 1'b0;
      gapCnt   <= GAP_SAT;
      locked   <= 1'b0;
    end else begin
      modeReg  <= modeSel;
      syncPrev <= syncIn;
      if (edgeDet)
        gapCnt <= GAP_W'(1);
      else if (gapCnt != GAP_SAT)
        gapCnt <= gapCnt + GAP_W'(1);
      if (modeChg)
        locked <= 1'b0;
      else if (edgeDet)
        locked <= aligned;
    end
  end

  // R6: lock can only appear right after a sync edge
  a_r6_lock_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(edgeDet));

  // R7: a misaligned edge with no mode change drops lock
  a_r7_misaligned_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (edgeDet && !aligned) |=> !locked);

  // R5: a mode change drops lock
  a_r5_mode_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> !locked);

endmodule

// File: rtl/mtg_datapath.sv
module mtg_datapath
  import mtg_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [LEN_W-1:0] curLen,
  output logic [CNT_W-1:0] cnt,
  output logic             loadStb,
  output logic             slowClk
);

  logic [LEN_W-1:0] lastPos;
  logic [LEN_W-1:0] halfLen;
  logic             wrapNow;

  assign lastPos = curLen - LEN_W'(1);
  assign halfLen = curLen >> 1;
  assign wrapNow = ({1'b0, cnt} == lastPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (strobes.clearCnt)
      cnt <= '0;
    else if (wrapNow)
      cnt <= '0;
    else
      cnt <= cnt + CNT_W'(1);
  end

  assign loadStb = (cnt == '0);
  assign slowClk = ({1'b0, cnt} < halfLen);

  // R1: the count never leaves the word
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, cnt} < curLen);

  // R4: a clear request lands as a zero count
  a_r4_clear_gives_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> (cnt == '0));

  // R2: the load strobe lasts a single cycle unless re-cleared
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !strobes.clearCnt) |=> !loadStb);

  // R3: the slow clock only rises at a word boundary
  a_r3_slow_rises_on_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slowClk) |-> loadStb);

endmodule

// File: rtl/modulus_timing_gen.sv
module modulus_timing_gen
  import mtg_pkg::*;
#(
  parameter int LEN0 = 4,
  parameter int LEN1 = 5,
  parameter int LEN2 = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       syncIn,
  output logic       loadStb,
  output logic       slowClk,
  output logic       locked
);

  localparam int MAX_LEN = (LEN0 > LEN1) ? ((LEN0 > LEN2) ? LEN0 : LEN2)
                                         : ((LEN1 > LEN2) ? LEN1 : LEN2);
  localparam int CNT_W = $clog2(MAX_LEN);
  localparam int LEN_W = CNT_W + 1;
  localparam int GAP_W = CNT_W + 2;

  strobeT           strobes;
  logic [LEN_W-1:0] curLen;
  logic [CNT_W-1:0] cnt;

  mtg_ctrl #(
    .LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2),
    .CNT_W(CNT_W), .LEN_W(LEN_W), .GAP_W(GAP_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .syncIn(syncIn),
    .cnt(cnt), .strobes(strobes), .curLen(curLen), .locked(locked)
  );

  mtg_datapath #(
    .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curLen(curLen),
    .cnt(cnt), .loadStb(loadStb), .slowClk(slowClk)
  );

endmodule

// File: tb/modulus_timing_gen_tb_top.sv
module modulus_timing_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       syncIn = 1'b0;
  logic       loadStb, slowClk, locked;
  logic       sLoad, sSlow, sLocked;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int  mCnt = 0;
  int  mMode = 0;
  bit  mPrev = 0;
  int  mGap = 15;
  bit  mLocked = 0;

  always #4 clk = ~clk;

  modulus_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .syncIn(syncIn),
    .loadStb(loadStb), .slowClk(slowClk), .locked(locked)
  );

  // slave driven by the master slow clock
  modulus_timing_gen slave_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .syncIn(slowClk),
    .loadStb(sLoad), .slowClk(sSlow), .locked(sLocked)
  );

  function automatic int lenOf(input int code);
    if (code == 0) return 4;
    if (code == 1) return 5;
    return 8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelTick(input int m, input bit s);
    bit edgeSeen;
    int len;
    edgeSeen = s && !mPrev;
    mPrev = s;
    len = lenOf(mMode);
    if (m != mMode) begin
      mMode = m; mCnt = 0; mLocked = 0;
    end else if (edgeSeen) begin
      mLocked = (mGap == len) && (mCnt == len - 1);
      mCnt = 0;
    end else begin
      mCnt = (mCnt == len - 1) ? 0 : mCnt + 1;
    end
    if (edgeSeen) mGap = 1;
    else if (mGap < 15) mGap = mGap + 1;
  endtask

  task automatic compareAll();
    int expLoad, expSlow;
    expLoad = (mCnt == 0) ? 1 : 0;
    expSlow = (mCnt < lenOf(mMode) / 2) ? 1 : 0;
    check(loadStb == expLoad, "R2 loadStb", int'(loadStb), expLoad);
    check(slowClk == expSlow, "R3 slowClk", int'(slowClk), expSlow);
    check(locked == mLocked, "R6 locked", int'(locked), int'(mLocked));
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input int m, input bit s);
    modeSel = m[1:0];
    syncIn = s;
    @(posedge clk);
    modelTick(m, s);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int loads;
    int firstEdge;
    int lockAt;
    int ph;
    int curM;
    int prevM;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset values
    check(loadStb == 1'b1, "R8 loadStb at reset", int'(loadStb), 1);
    check(slowClk == 1'b1, "R8 slowClk at reset", int'(slowClk), 1);
    check(locked == 1'b0, "R8 locked at reset", int'(locked), 0);
    rstN = 1'b1;

    // R1: free-running periods in every mode
    for (int code = 0; code < 4; code++) begin
      step(code, 0);
      loads = 0;
      for (int i = 0; i < 40; i++) begin
        step(code, 0);
        if (loadStb) loads++;
      end
      check(loads == 40 / lenOf(code), "R1 loads per 40 cycles", loads, 40 / lenOf(code));
    end

    // R4: an edge forces the boundary on the next cycle
    step(2, 0); step(2, 0); step(2, 0);
    step(2, 1);
    check(loadStb == 1'b1, "R4 load after edge", int'(loadStb), 1);
    step(2, 0);

    // R6 and R7: lock on a steady sync clock, then shift it
    firstEdge = -1; lockAt = -1;
    for (int i = 0; i < 36; i++) begin
      bit s;
      s = (i < 30) ? (((i + 3) % 8) < 4) : (((i + 5) % 8) < 4);
      step(2, s);
      if (firstEdge < 0 && s && !((i > 0) && (((i + 2) % 8) < 4))) firstEdge = i;
      if (lockAt < 0 && locked) lockAt = i;
    end
    check(lockAt >= 0 && (lockAt - firstEdge) <= 16, "R6 lock latency",
          lockAt - firstEdge, 16);
    check(locked == 1'b0, "R7 misaligned edge unlocks", int'(locked), 0);

    // relock, then R10: hold sync high
    for (int i = 0; i < 24; i++) step(2, (i % 8) < 4);
    check(locked == 1'b1, "R6 relocked", int'(locked), 1);
    loads = 0;
    for (int i = 0; i < 32; i++) begin
      step(2, 1);
      if (loadStb) loads++;
    end
    check(loads == 4, "R10 steady high sync", loads, 4);

    // R5: a mode change restarts and unlocks, even with an edge present
    for (int i = 0; i < 24; i++) step(2, (i % 8) < 4);
    check(locked == 1'b1, "R5 locked before change", int'(locked), 1);
    step(1, 0);
    step(0, 1);
    check(loadStb == 1'b1, "R5 restart at zero", int'(loadStb), 1);
    check(locked == 1'b0, "R5 unlocked", int'(locked), 0);

    // random section
    curM = 1; ph = 0;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2) begin
        curM = int'($urandom_range(0, 3));
        ph = 0;
      end
      if (r >= 2 && r < 7) ph = ph + 1;
      if (r >= 95) step(curM, 1'($urandom_range(0, 1)));
      else begin
        step(curM, (ph % lenOf(curM)) < (lenOf(curM) / 2));
        ph = ph + 1;
      end
    end

    // R9: master drives the slave
    for (int i = 0; i < 40; i++) step(1, 0);
    for (int i = 0; i < 20; i++) begin
      prevM = int'(loadStb);
      step(1, 0);
      check(sLoad == prevM, "R9 slave lags master", int'(sLoad), prevM);
    end
    check(sLocked == 1'b1, "R9 slave locked", int'(sLocked), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule